// File: doc/BRIEF.md
# Segment/Page Address Translation Front End

This block sits between a CPU access port and a paged TLB and decides, for each access, how the virtual address becomes a physical one. It takes a virtual address, an access kind (read, write or instruction fetch) and a user/kernel flag. There are three outcomes. When translation is switched off, the address passes through unchanged. When a kernel access falls in a 256 MiB region that is marked for direct mapping, the upper nibble is replaced from a packed base register. Every other access is forwarded to the paged lookup port.

The block holds a small register set written through a simple select/data port: a global control value, a per-region direct-map mask and two base registers with one nibble per region. Direct results come back one cycle after the request. A paged request leaves on the lookup port one cycle after the request. The answer from the lookup port reaches the response outputs one cycle after it arrives, with its fields unchanged. The requester keeps at most one paged lookup outstanding and issues no new request in the cycle a paged answer returns.

Top module: `seg_xlate_front`

## Requirements
- R1: A synchronous active-high reset clears all four registers, `rsp_valid` and `pg_req_valid`. The first access after reset is therefore translated with translation switched off.
- R2: While control bits [3:2] are both zero, an access gives `rsp_paddr` equal to `req_vaddr` with `rsp_perm`=3'b111 one cycle later, whatever the region mask holds. The other control bits have no effect.
- R3: Translation is on when control bit 2 or bit 3 (or both) is set.
- R4: With translation on, a kernel access (`req_user`=0) whose region `req_vaddr[31:28]` has its bit set in the 16-bit region mask responds one cycle later with `rsp_paddr` = {base nibble, `req_vaddr[27:0]`} and `rsp_perm`=3'b111. It issues no paged request.
- R5: Regions 0 to 7 take their nibble from base-low bits [4*r+3:4*r], and regions 8 to 15 from base-high bits [4*(r-8)+3:4*(r-8)].
- R6: A user access (`req_user`=1) is never direct-mapped, even when its region bit is set. It goes to the paged port.
- R7: A paged access raises `pg_req_valid` one cycle after the request. `pg_req_vaddr`, `pg_req_kind` and `pg_req_user` are copied from the request. `pg_req_itlb`=1 only for a fetch (`req_kind`=2'b10); a read (2'b00) or write (2'b01) gives 0.
- R8: One cycle after `pg_rsp_valid`, `rsp_valid` is 1 and `rsp_paddr`, `rsp_perm`, `rsp_fault` and `rsp_vec` equal the lookup port's values.
- R9: Pass-through and direct-mapped responses report `rsp_fault`=0 and `rsp_vec`=0.
- R10: Register select codes for `cfg_sel`: 0 = control, 1 = region mask (data bits [15:0]), 2 = base-low, 3 = base-high. A write is seen by requests issued from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Access request strobe |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 00 read, 01 write, 10 fetch |
| req_user | input | 1 | 1 = user-mode access |
| pg_req_valid | output | 1 | Paged lookup request |
| pg_req_vaddr | output | 32 | Address for paged lookup |
| pg_req_kind | output | 2 | Access kind for paged lookup |
| pg_req_user | output | 1 | User flag for paged lookup |
| pg_req_itlb | output | 1 | 1 = instruction TLB, 0 = data TLB |
| pg_rsp_valid | input | 1 | Paged lookup answer strobe |
| pg_rsp_paddr | input | 32 | Paged physical address |
| pg_rsp_perm | input | 3 | Paged permissions |
| pg_rsp_fault | input | 1 | Paged miss/fault flag |
| pg_rsp_vec | input | 4 | Paged exception vector |
| rsp_valid | output | 1 | Translation result strobe |
| rsp_paddr | output | 32 | Physical address |
| rsp_perm | output | 3 | Permissions {exec, write, read} |
| rsp_fault | output | 1 | Miss/fault flag |
| rsp_vec | output | 4 | Exception vector |

## Verification
The bench builds the block with its default parameters: a 32-bit address, 4-bit region field and 16 regions split over two 32-bit base registers. This size reaches both base registers, the first and last nibble of each, and the boundary between region 7 and region 8. The tests run kernel and user accesses to the same mapped region so that the user/kernel split is seen at the outputs. They also use control values with only bits [1:0] set, or only bit 3 set, to probe the enable decode.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'b00,
    SEL_MASK   = 2'b01,
    SEL_BASELO = 2'b10,
    SEL_BASEHI = 2'b11
  } reg_sel_e;
endpackage

// File: rtl/seg_xlate_regs.sv
module seg_xlate_regs #(
  parameter int REG_W  = 32,
  parameter int NSEG   = 16,
  parameter int BASE_W = 32,
  parameter int EN_LSB = 2,
  parameter int EN_MSB = 3,
  localparam int EN_W  = EN_MSB - EN_LSB + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic [REG_W-1:0]  wdata,
  output logic [EN_W-1:0]   ctrl_en,
  output logic [NSEG-1:0]   seg_mask,
  output logic [BASE_W-1:0] base_lo,
  output logic [BASE_W-1:0] base_hi
);
  import seg_xlate_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en  <= '0;
      seg_mask <= '0;
      base_lo  <= '0;
      base_hi  <= '0;
    end else if (we) begin
      case (reg_sel_e'(sel))
        SEL_CTRL:   ctrl_en  <= wdata[EN_MSB:EN_LSB];
        SEL_MASK:   seg_mask <= wdata[NSEG-1:0];
        SEL_BASELO: base_lo  <= wdata[BASE_W-1:0];
        SEL_BASEHI: base_hi  <= wdata[BASE_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/seg_xlate_decode.sv
module seg_xlate_decode #(
  parameter int VA_W     = 32,
  parameter int SEG_BITS = 4,
  parameter int EN_W     = 2,
  localparam int NSEG    = 2 ** SEG_BITS,
  localparam int HALF    = NSEG / 2,
  localparam int BASE_W  = HALF * SEG_BITS,
  localparam int OFF_W   = VA_W - SEG_BITS
) (
  input  logic [EN_W-1:0]     ctrl_en,
  input  logic [NSEG-1:0]     seg_mask,
  input  logic [BASE_W-1:0]   base_lo,
  input  logic [BASE_W-1:0]   base_hi,
  input  logic [VA_W-1:0]     vaddr,
  input  logic                user,
  output logic                mmu_on,
  output logic                go_paged,
  output logic [VA_W-1:0]     direct_paddr
);
  logic [SEG_BITS-1:0] nib [NSEG];
  logic [SEG_BITS-1:0] seg;
  logic                seg_hit;

  for (genvar g = 0; g < NSEG; g++) begin : g_nib
    if (g < HALF) begin : g_lo
      assign nib[g] = base_lo[g*SEG_BITS +: SEG_BITS];
    end else begin : g_hi
      assign nib[g] = base_hi[(g-HALF)*SEG_BITS +: SEG_BITS];
    end
  end

  always_comb begin
    seg      = vaddr[VA_W-1 -: SEG_BITS];
    mmu_on   = |ctrl_en;
    seg_hit  = !user && seg_mask[seg];
    go_paged = mmu_on && !seg_hit;
    if (!mmu_on) direct_paddr = vaddr;
    else         direct_paddr = {nib[seg], vaddr[OFF_W-1:0]};
  end
endmodule

// File: rtl/seg_xlate_front.sv
module seg_xlate_front #(
  parameter int VA_W     = 32,
  parameter int SEG_BITS = 4,
  parameter int REG_W    = 32,
  parameter int PERM_W   = 3,
  parameter int VEC_W    = 4,
  parameter int EN_LSB   = 2,
  parameter int EN_MSB   = 3,
  localparam int NSEG    = 2 ** SEG_BITS,
  localparam int BASE_W  = (NSEG / 2) * SEG_BITS,
  localparam int EN_W    = EN_MSB - EN_LSB + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [1:0]        req_kind,
  input  logic              req_user,
  output logic              pg_req_valid,
  output logic [VA_W-1:0]   pg_req_vaddr,
  output logic [1:0]        pg_req_kind,
  output logic              pg_req_user,
  output logic              pg_req_itlb,
  input  logic              pg_rsp_valid,
  input  logic [VA_W-1:0]   pg_rsp_paddr,
  input  logic [PERM_W-1:0] pg_rsp_perm,
  input  logic              pg_rsp_fault,
  input  logic [VEC_W-1:0]  pg_rsp_vec,
  output logic              rsp_valid,
  output logic [VA_W-1:0]   rsp_paddr,
  output logic [PERM_W-1:0] rsp_perm,
  output logic              rsp_fault,
  output logic [VEC_W-1:0]  rsp_vec
);
  import seg_xlate_pkg::*;

  logic [EN_W-1:0]   ctrl_en;
  logic [NSEG-1:0]   seg_mask;
  logic [BASE_W-1:0] base_lo, base_hi;
  logic              mmu_on, go_paged;
  logic [VA_W-1:0]   direct_paddr;

  seg_xlate_regs #(
    .REG_W(REG_W), .NSEG(NSEG), .BASE_W(BASE_W),
    .EN_LSB(EN_LSB), .EN_MSB(EN_MSB)
  ) regs_i (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .ctrl_en(ctrl_en), .seg_mask(seg_mask), .base_lo(base_lo), .base_hi(base_hi)
  );

  seg_xlate_decode #(
    .VA_W(VA_W), .SEG_BITS(SEG_BITS), .EN_W(EN_W)
  ) dec_i (
    .ctrl_en(ctrl_en), .seg_mask(seg_mask), .base_lo(base_lo), .base_hi(base_hi),
    .vaddr(req_vaddr), .user(req_user),
    .mmu_on(mmu_on), .go_paged(go_paged), .direct_paddr(direct_paddr)
  );

  // Paged lookup request register
  always_ff @(posedge clk) begin
    if (rst) begin
      pg_req_valid <= 1'b0;
      pg_req_vaddr <= '0;
      pg_req_kind  <= '0;
      pg_req_user  <= 1'b0;
      pg_req_itlb  <= 1'b0;
    end else begin
      pg_req_valid <= req_valid && go_paged;
      if (req_valid && go_paged) begin
        pg_req_vaddr <= req_vaddr;
        pg_req_kind  <= req_kind;
        pg_req_user  <= req_user;
        pg_req_itlb  <= (acc_kind_e'(req_kind) == ACC_FETCH);
      end
    end
  end

  // Response register: a returning paged answer takes the slot
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_perm  <= '0;
      rsp_fault <= 1'b0;
      rsp_vec   <= '0;
    end else if (pg_rsp_valid) begin
      rsp_valid <= 1'b1;
      rsp_paddr <= pg_rsp_paddr;
      rsp_perm  <= pg_rsp_perm;
      rsp_fault <= pg_rsp_fault;
      rsp_vec   <= pg_rsp_vec;
    end else if (req_valid && !go_paged) begin
      rsp_valid <= 1'b1;
      rsp_paddr <= direct_paddr;
      rsp_perm  <= '1;
      rsp_fault <= 1'b0;
      rsp_vec   <= '0;
    end else begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int VA_W   = 32,
  parameter int PERM_W = 3,
  parameter int VEC_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [VA_W-1:0]   req_vaddr,
  input logic [1:0]        req_kind,
  input logic              req_user,
  input logic              mmu_on,
  input logic              pg_req_valid,
  input logic              pg_req_itlb,
  input logic              pg_rsp_valid,
  input logic              pg_rsp_fault,
  input logic [VEC_W-1:0]  pg_rsp_vec,
  input logic              rsp_valid,
  input logic [VA_W-1:0]   rsp_paddr,
  input logic [PERM_W-1:0] rsp_perm,
  input logic              rsp_fault,
  input logic [VEC_W-1:0]  rsp_vec
);
  // R7
  pg_req_has_src_chk: assert property (@(posedge clk) disable iff (rst)
    pg_req_valid |-> $past(req_valid));

  // R7
  pg_req_tlb_pick_chk: assert property (@(posedge clk) disable iff (rst)
    pg_req_valid |-> (pg_req_itlb == ($past(req_kind) == 2'b10)));

  // R6
  user_goes_paged_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_user && mmu_on) |=> pg_req_valid);

  // R8
  pg_rsp_passthru_chk: assert property (@(posedge clk) disable iff (rst)
    pg_rsp_valid |=> (rsp_valid && rsp_fault == $past(pg_rsp_fault)
                      && rsp_vec == $past(pg_rsp_vec)));

  // R9
  direct_no_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !$past(pg_rsp_valid)) |-> (!rsp_fault && rsp_vec == '0 && rsp_perm == '1));

  // R2
  bypass_ident_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !mmu_on && !pg_rsp_valid) |=> (rsp_valid && rsp_paddr == $past(req_vaddr)));
endmodule

bind seg_xlate_front seg_xlate_chk #(
  .VA_W(VA_W), .PERM_W(PERM_W), .VEC_W(VEC_W)
) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
  .req_kind(req_kind), .req_user(req_user), .mmu_on(mmu_on),
  .pg_req_valid(pg_req_valid), .pg_req_itlb(pg_req_itlb),
  .pg_rsp_valid(pg_rsp_valid), .pg_rsp_fault(pg_rsp_fault), .pg_rsp_vec(pg_rsp_vec),
  .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_perm(rsp_perm),
  .rsp_fault(rsp_fault), .rsp_vec(rsp_vec)
);

// File: tb/seg_xlate_front_tb_top.sv
module seg_xlate_front_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic        req_valid;
  logic [31:0] req_vaddr;
  logic [1:0]  req_kind;
  logic        req_user;
  logic        pg_req_valid;
  logic [31:0] pg_req_vaddr;
  logic [1:0]  pg_req_kind;
  logic        pg_req_user;
  logic        pg_req_itlb;
  logic        pg_rsp_valid;
  logic [31:0] pg_rsp_paddr;
  logic [2:0]  pg_rsp_perm;
  logic        pg_rsp_fault;
  logic [3:0]  pg_rsp_vec;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic [2:0]  rsp_perm;
  logic        rsp_fault;
  logic [3:0]  rsp_vec;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  seg_xlate_front dut_i (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Issue one access; for paged ones act as the TLB and answer once.
  task automatic access(input logic [31:0] va, input logic [1:0] kind, input logic usr,
                        input bit exp_paged, input logic [31:0] exp_pa, input string req);
    logic [31:0] tpa;
    logic [2:0]  tperm;
    logic        tflt;
    logic [3:0]  tvec;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_kind = kind; req_user = usr;
    @(negedge clk);
    req_valid = 1'b0;
    if (exp_paged) begin
      chk(pg_req_valid == 1'b1, req, "pg_req_valid", {31'd0, pg_req_valid}, 32'd1);
      chk(rsp_valid == 1'b0, req, "rsp_valid early", {31'd0, rsp_valid}, 32'd0);
      chk(pg_req_vaddr == va, "R7", "pg_req_vaddr", pg_req_vaddr, va);
      chk(pg_req_kind == kind && pg_req_user == usr, "R7", "pg_req kind/user",
          {29'd0, pg_req_kind, pg_req_user}, {29'd0, kind, usr});
      chk(pg_req_itlb == (kind == 2'b10), "R7", "pg_req_itlb",
          {31'd0, pg_req_itlb}, {31'd0, kind == 2'b10});
      tpa = va ^ 32'h5A5A_0000; tperm = 3'b101; tflt = va[0]; tvec = va[4:1];
      pg_rsp_valid = 1'b1; pg_rsp_paddr = tpa; pg_rsp_perm = tperm;
      pg_rsp_fault = tflt; pg_rsp_vec = tvec;
      @(negedge clk);
      pg_rsp_valid = 1'b0;
      chk(rsp_valid == 1'b1 && rsp_paddr == tpa, "R8", "paged rsp paddr", rsp_paddr, tpa);
      chk(rsp_perm == tperm && rsp_fault == tflt && rsp_vec == tvec, "R8", "paged rsp perm/fault/vec",
          {24'd0, rsp_perm, rsp_fault, rsp_vec}, {24'd0, tperm, tflt, tvec});
    end else begin
      chk(pg_req_valid == 1'b0, req, "no pg_req", {31'd0, pg_req_valid}, 32'd0);
      chk(rsp_valid == 1'b1 && rsp_paddr == exp_pa, req, "direct paddr", rsp_paddr, exp_pa);
      chk(rsp_perm == 3'b111, req, "direct perm", {29'd0, rsp_perm}, 32'd7);
      chk(rsp_fault == 1'b0 && rsp_vec == 4'd0, "R9", "direct fault/vec",
          {27'd0, rsp_fault, rsp_vec}, 32'd0);
    end
  endtask

  // {vaddr, kind, user, paged, expected paddr}
  localparam int NV = 8;
  localparam logic [67:0] VEC [NV] = '{
    {32'h0123_4567, 2'b00, 1'b0, 1'b0, 32'h1123_4567},
    {32'h7FFF_FFFF, 2'b01, 1'b0, 1'b0, 32'h9FFF_FFFF},
    {32'h8000_0010, 2'b10, 1'b0, 1'b0, 32'h8000_0010},
    {32'hF0AB_CDEF, 2'b00, 1'b0, 1'b0, 32'h20AB_CDEF},
    {32'h0123_4567, 2'b00, 1'b1, 1'b1, 32'h0},
    {32'h1000_0000, 2'b01, 1'b0, 1'b1, 32'h0},
    {32'h8000_0011, 2'b10, 1'b1, 1'b1, 32'h0},
    {32'h3456_789A, 2'b10, 1'b0, 1'b1, 32'h0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    req_valid = 1'b0; req_vaddr = '0; req_kind = '0; req_user = 1'b0;
    pg_rsp_valid = 1'b0; pg_rsp_paddr = '0; pg_rsp_perm = '0;
    pg_rsp_fault = 1'b0; pg_rsp_vec = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(rsp_valid == 1'b0 && pg_req_valid == 1'b0, "R1", "outputs in reset",
        {30'd0, rsp_valid, pg_req_valid}, 32'd0);
    rst = 1'b0;
    // R1: registers cleared -> translation off
    access(32'hC0DE_1234, 2'b00, 1'b1, 1'b0, 32'hC0DE_1234, "R1");

    // R10 register program; R5 base layout
    wr(2'b01, 32'hFFFF_8181);  // regions 0,7,8,15
    wr(2'b10, 32'h9ABC_DEF1);  // region0 nib 1, region7 nib 9
    wr(2'b11, 32'h2345_6788);  // region8 nib 8, region15 nib 2
    wr(2'b00, 32'h0000_0003);  // bits [1:0] only: still off
    // R2: mask set but translation off
    access(32'h0123_4567, 2'b00, 1'b0, 1'b0, 32'h0123_4567, "R2");
    wr(2'b00, 32'h0000_0008);  // only bit 3
    // R3: bit 3 alone enables
    access(32'h0123_4567, 2'b00, 1'b0, 1'b0, 32'h1123_4567, "R3");
    wr(2'b00, 32'h0000_0004);  // only bit 2

    // Table walk: R4/R5 direct, R6/R7/R8 paged
    for (int i = 0; i < NV; i++) begin
      access(VEC[i][67:36], VEC[i][35:34], VEC[i][33], VEC[i][32], VEC[i][31:0],
             VEC[i][32] ? (VEC[i][33] ? "R6" : "R7") : "R4/R5");
    end

    // R10: mask update seen by next access; region 1 now direct, region 0 paged
    wr(2'b01, 32'h0000_0002);
    access(32'h1ABC_0000, 2'b00, 1'b0, 1'b0, 32'hFABC_0000, "R10");
    access(32'h0123_4567, 2'b00, 1'b0, 1'b1, 32'h0, "R10");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule